// File: doc/BRIEF.md
# Wide-Port Adapter for a Narrow-Word Memory

This block lets a client that moves several memory words per access talk to a memory whose words are narrow. The wide data port is a power-of-two multiple of the memory word width. Each wide access covers an aligned group of consecutive words. The adapter splits that access into one sub-port per word. The first sub-port is the lead and the others are continuations. Every sub-port receives the same clock, enable and reset controls, and differs only in the sub-word index placed in the low address bits. For a read, the adapter joins the returned words into one wide value. For a write, it cuts the data and the per-bit enables into word slices. The narrow memory behind the adapter is a plain register array, cleared by reset, which makes the block usable standalone in tests.

Addresses on the wide port are word addresses. When an access names an address whose low log2(RATIO) bits are not zero, it is refused. A refused write leaves the memory unchanged, and a refused read leaves the read output unchanged. The refusal also raises a sticky error flag, which only reset clears.

Top module: `wide_mem_adapter`

## Requirements
- R1: While `rst` is high, `rd_data` becomes zero, `align_err` becomes zero and every memory word is cleared, so any aligned read made after reset returns zero.
- R2: An aligned read (`rd_en`=1, `rd_addr` low log2(RATIO) bits zero) updates `rd_data` at the next rising edge. Bits [k*WORD_W +: WORD_W] hold the word at address `rd_addr`+k, so sub-word 0 is the least significant.
- R3: An aligned write (`wr_en`=1) writes bit b of word `wr_addr`+k from `wr_data`[k*WORD_W+b] only where `wr_bits`[k*WORD_W+b] is 1. Every other bit of those words keeps its value.
- R4: A write changes only the RATIO words of its own aligned group, and neighbouring groups read back unchanged.
- R5: With `rd_en`=0 and `rd_clr`=0, `rd_data` holds its value.
- R6: `rd_clr`=1 sets `rd_data` to zero at the next edge, taking priority over a read issued in the same cycle.
- R7: When a read and a write target the same group in the same cycle, the read returns the contents from before the write. A later read returns the new contents.
- R8: A read or write whose address has a nonzero low part is refused: the memory does not change, `rd_data` holds (unless `rd_clr`), and `align_err` is 1 from the next edge.
- R9: Once set, `align_err` stays at 1 through any later traffic until `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Wide read request |
| rd_clr | input | 1 | Synchronous clear of the read output |
| rd_addr | input | ADDR_W | Word address of the read group |
| rd_data | output | WORD_W*RATIO | Joined read words, registered |
| wr_en | input | 1 | Wide write request |
| wr_addr | input | ADDR_W | Word address of the write group |
| wr_data | input | WORD_W*RATIO | Wide write data |
| wr_bits | input | WORD_W*RATIO | Per-bit write enables |
| align_err | output | 1 | Sticky misaligned-access flag |

## Verification
A wrong sub-word index or a wrong data slice would leave words misplaced inside `rd_data` or stored in a neighbouring group. These faults appear on the first read of the affected group, one edge after it is issued. Bad enable slicing shows up as corrupted kept bits on the read that follows a partial write. A broken alignment guard shows up as `align_err` changing on the edge after the stimulus. A leaking refused access shows up on the next aligned read of the group it would have touched.

// File: rtl/wma_pkg.sv
package wma_pkg;

    // Controls shared by every sub-port of one wide access.
    typedef struct packed {
        logic rd_go;
        logic rd_clr;
        logic wr_go;
    } wma_ctrl_t;

    // Next action of a registered read output.
    typedef enum logic [1:0] {
        RD_HOLD  = 2'd0,
        RD_LOAD  = 2'd1,
        RD_CLEAR = 2'd2
    } wma_rd_act_e;

    // True when the low n bits of an address are all zero.
    function automatic logic low_bits_zero(input logic [31:0] addr, input int unsigned n);
        logic [31:0] mask;
        mask = (32'd1 << n) - 32'd1;
        return (addr & mask) == 32'd0;
    endfunction

endpackage

// File: rtl/wma_align_guard.sv
module wma_align_guard
    import wma_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LOG_R  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              rd_clr,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output wma_ctrl_t         ctrl,
    output logic              align_err
);
    logic rd_ok, wr_ok, bad_now;

    always_comb begin
        rd_ok       = low_bits_zero(32'(rd_addr), LOG_R);
        wr_ok       = low_bits_zero(32'(wr_addr), LOG_R);
        ctrl.rd_go  = rd_en & rd_ok;
        ctrl.wr_go  = wr_en & wr_ok;
        ctrl.rd_clr = rd_clr;
        bad_now     = (rd_en & ~rd_ok) | (wr_en & ~wr_ok);
    end

    always_ff @(posedge clk) begin
        if (rst)
            align_err <= 1'b0;
        else if (bad_now)
            align_err <= 1'b1;
    end
endmodule

// File: rtl/wma_splitter.sv
module wma_splitter #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 8,
    parameter int RATIO  = 4,
    localparam int LOG_R = $clog2(RATIO),
    localparam int GRP_W = ADDR_W - LOG_R
) (
    input  logic [GRP_W-1:0]                   rd_group,
    input  logic [GRP_W-1:0]                   wr_group,
    input  logic [RATIO*WORD_W-1:0]            wide_wdata,
    input  logic [RATIO*WORD_W-1:0]            wide_wbits,
    output logic [RATIO-1:0][ADDR_W-1:0]       sub_raddr,
    output logic [RATIO-1:0][ADDR_W-1:0]       sub_waddr,
    output logic [RATIO-1:0][WORD_W-1:0]       sub_wdata,
    output logic [RATIO-1:0][WORD_W-1:0]       sub_wbits
);
    // Sub-port 0 is the lead; the rest are continuations that differ only in
    // the sub-word index carried in the low address bits.
    for (genvar k = 0; k < RATIO; k++) begin : g_sub
        assign sub_raddr[k] = {rd_group, LOG_R'(k)};
        assign sub_waddr[k] = {wr_group, LOG_R'(k)};
        assign sub_wdata[k] = wide_wdata[k*WORD_W +: WORD_W];
        assign sub_wbits[k] = wide_wbits[k*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/wma_narrow_mem.sv
module wma_narrow_mem
    import wma_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 8,
    parameter int PORTS  = 4,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  wma_ctrl_t                    ctrl,
    input  logic [PORTS-1:0][ADDR_W-1:0] raddr,
    input  logic [PORTS-1:0][ADDR_W-1:0] waddr,
    input  logic [PORTS-1:0][WORD_W-1:0] wdata,
    input  logic [PORTS-1:0][WORD_W-1:0] wbits,
    output logic [PORTS-1:0][WORD_W-1:0] rword
);
    logic [WORD_W-1:0] mem [DEPTH];
    wma_rd_act_e       act;

    always_comb begin
        if (ctrl.rd_clr)
            act = RD_CLEAR;
        else if (ctrl.rd_go)
            act = RD_LOAD;
        else
            act = RD_HOLD;
    end

    // Write ports of one wide access always hit distinct words.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < DEPTH; a++)
                mem[a] <= '0;
        end else if (ctrl.wr_go) begin
            for (int p = 0; p < PORTS; p++)
                for (int b = 0; b < WORD_W; b++)
                    if (wbits[p][b])
                        mem[waddr[p]][b] <= wdata[p][b];
        end
    end

    // Registered read ports; reads see the array before this edge's write.
    for (genvar p = 0; p < PORTS; p++) begin : g_rd
        always_ff @(posedge clk) begin
            if (rst)
                rword[p] <= '0;
            else begin
                case (act)
                    RD_CLEAR: rword[p] <= '0;
                    RD_LOAD:  rword[p] <= mem[raddr[p]];
                    default:  rword[p] <= rword[p];
                endcase
            end
        end
    end
endmodule

// File: rtl/wide_mem_adapter.sv
module wide_mem_adapter
    import wma_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int RATIO  = 4,
    parameter int DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int LOG_R  = $clog2(RATIO),
    localparam int WIDE_W = WORD_W * RATIO
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              rd_clr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WIDE_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDE_W-1:0] wr_data,
    input  logic [WIDE_W-1:0] wr_bits,
    output logic              align_err
);
    wma_ctrl_t                         ctrl;
    logic [RATIO-1:0][ADDR_W-1:0]      sub_raddr, sub_waddr;
    logic [RATIO-1:0][WORD_W-1:0]      sub_wdata, sub_wbits, sub_rword;

    wma_align_guard #(.ADDR_W(ADDR_W), .LOG_R(LOG_R)) u_guard (
        .clk(clk), .rst(rst),
        .rd_en(rd_en), .rd_clr(rd_clr), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr),
        .ctrl(ctrl), .align_err(align_err)
    );

    wma_splitter #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .RATIO(RATIO)) u_split (
        .rd_group(rd_addr[ADDR_W-1:LOG_R]),
        .wr_group(wr_addr[ADDR_W-1:LOG_R]),
        .wide_wdata(wr_data), .wide_wbits(wr_bits),
        .sub_raddr(sub_raddr), .sub_waddr(sub_waddr),
        .sub_wdata(sub_wdata), .sub_wbits(sub_wbits)
    );

    wma_narrow_mem #(.DEPTH(DEPTH), .WORD_W(WORD_W), .PORTS(RATIO)) u_mem (
        .clk(clk), .rst(rst), .ctrl(ctrl),
        .raddr(sub_raddr), .waddr(sub_waddr),
        .wdata(sub_wdata), .wbits(sub_wbits),
        .rword(sub_rword)
    );

    // Sub-port k lands in bits [k*WORD_W +: WORD_W].
    assign rd_data = sub_rword;
endmodule

// File: rtl/wma_checker.sv
module wma_checker #(
    parameter int ADDR_W = 6,
    parameter int LOG_R  = 2,
    parameter int WIDE_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic              rd_clr,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [WIDE_W-1:0] rd_data,
    input logic              align_err
);
    logic rd_mis, wr_mis;
    assign rd_mis = rd_en && (rd_addr[LOG_R-1:0] != '0);
    assign wr_mis = wr_en && (wr_addr[LOG_R-1:0] != '0);

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !rd_clr) |=> $stable(rd_data));

    // R6
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        rd_clr |=> (rd_data == '0));

    // R8
    misaligned_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_mis || wr_mis) |=> align_err);

    // R8
    misaligned_read_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_mis && !rd_clr) |=> $stable(rd_data));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        align_err |=> align_err);
endmodule

bind wide_mem_adapter wma_checker #(.ADDR_W(ADDR_W), .LOG_R(LOG_R), .WIDE_W(WIDE_W)) u_wma_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_clr(rd_clr), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_data(rd_data), .align_err(align_err)
);

// File: tb/test_wide_mem_adapter.sv
module test_wide_mem_adapter;
    localparam int WORD_W = 8;
    localparam int RATIO  = 4;
    localparam int DEPTH  = 64;
    localparam int AW     = $clog2(DEPTH);
    localparam int WW     = WORD_W * RATIO;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic          rst = 1'b1;
    logic          rd_en = 1'b0, rd_clr = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] rd_addr = '0, wr_addr = '0;
    logic [WW-1:0] wr_data = '0, wr_bits = '0;
    logic [WW-1:0] rd_data;
    logic          align_err;

    wide_mem_adapter #(.WORD_W(WORD_W), .RATIO(RATIO), .DEPTH(DEPTH)) i_wide_mem_adapter (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_clr(rd_clr), .rd_addr(rd_addr),
        .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_bits(wr_bits), .align_err(align_err)
    );

    int total = 0, bad = 0, cyc = 0;

    // Scoreboard queues (one entry per expected result).
    logic [WW-1:0] q_data[$];
    logic          q_err[$];
    int            q_due[$];
    string         q_req[$];

    // Reference state built from the requirements.
    logic [WORD_W-1:0] model [DEPTH];
    logic [WW-1:0]     last_rd = '0;
    logic              err_m = 1'b0;

    task automatic check(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compares results one edge after the driver issued them.
    initial forever begin
        @(posedge clk);
        cyc++;
        #1;
        while (q_due.size() > 0 && q_due[0] == cyc) begin
            check({q_req[0], " rd_data"}, rd_data, q_data[0]);
            check({q_req[0], " align_err"}, WW'(align_err), WW'(q_err[0]));
            void'(q_data.pop_front());
            void'(q_err.pop_front());
            void'(q_due.pop_front());
            void'(q_req.pop_front());
        end
    end

    // Driver: one cycle of stimulus, pushing the expected outcome.
    task automatic step(input string req, input logic r, input logic [AW-1:0] ra, input logic c,
                        input logic w, input logic [AW-1:0] wa,
                        input logic [WW-1:0] wd, input logic [WW-1:0] wb);
        logic [WW-1:0] nxt;
        bit ra_ok, wa_ok;
        ra_ok = (int'(ra) % RATIO) == 0;
        wa_ok = (int'(wa) % RATIO) == 0;
        rd_en = r; rd_addr = ra; rd_clr = c;
        wr_en = w; wr_addr = wa; wr_data = wd; wr_bits = wb;
        nxt = last_rd;
        if (c)
            nxt = '0;
        else if (r && ra_ok)
            for (int k = 0; k < RATIO; k++)
                nxt[k*WORD_W +: WORD_W] = model[int'(ra) + k];
        if ((r && !ra_ok) || (w && !wa_ok))
            err_m = 1'b1;
        if (w && wa_ok)
            for (int k = 0; k < RATIO; k++)
                for (int b = 0; b < WORD_W; b++)
                    if (wb[k*WORD_W + b])
                        model[int'(wa) + k][b] = wd[k*WORD_W + b];
        last_rd = nxt;
        q_data.push_back(nxt);
        q_err.push_back(err_m);
        q_due.push_back(cyc + 1);
        q_req.push_back(req);
        @(negedge clk);
    endtask

    task automatic rd(input string req, input logic [AW-1:0] a);
        step(req, 1'b1, a, 1'b0, 1'b0, '0, '0, '0);
    endtask

    task automatic wr(input string req, input logic [AW-1:0] a, input logic [WW-1:0] d,
                      input logic [WW-1:0] m);
        step(req, 1'b0, '0, 1'b0, 1'b1, a, d, m);
    endtask

    task automatic idle(input string req);
        step(req, 1'b0, '0, 1'b0, 1'b0, '0, '0, '0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        rd_en = 1'b0; rd_clr = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state, R9 flag cleared only by reset
        check("R1 reset rd_data", rd_data, '0);
        check("R9 reset align_err", WW'(align_err), '0);
        for (int a = 0; a < DEPTH; a++) model[a] = '0;
        last_rd = '0;
        err_m = 1'b0;
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // R1: every group reads zero after reset
        for (int g = 0; g < DEPTH / RATIO; g++)
            rd("R1 cleared memory", AW'(g * RATIO));

        // R2: full writes then reads, word order checked by the model
        wr("R2 write", 6'd0,  32'hA4A3_A2A1, '1);
        wr("R2 write", 6'd16, 32'h1122_3344, '1);
        rd("R2 read group 0", 6'd0);
        rd("R2 read group 4", 6'd16);

        // R3: partial per-bit enables
        wr("R3 partial write", 6'd0, 32'h5A5A_5A5A, 32'h0F0F_00FF);
        rd("R3 partial read", 6'd0);

        // R4: neighbours untouched
        rd("R4 neighbour group 1", 6'd4);
        rd("R4 group 4 intact", 6'd16);

        // R5: hold
        idle("R5 hold");
        idle("R5 hold");

        // R6: clear beats read
        step("R6 clear with read", 1'b1, 6'd16, 1'b1, 1'b0, '0, '0, '0);
        rd("R6 read after clear", 6'd16);

        // R7: read and write same group same cycle
        step("R7 old data", 1'b1, 6'd16, 1'b0, 1'b1, 6'd16, 32'hDEAD_BEEF, '1);
        rd("R7 new data", 6'd16);

        // R8: refused write, then refused read
        wr("R8 misaligned write", 6'd17, 32'hFFFF_FFFF, '1);
        rd("R8 group unchanged", 6'd16);
        rd("R8 misaligned read", 6'd5);
        wr("R8 misaligned write 2", 6'd2, 32'h0BAD_0BAD, '1);
        rd("R8 group 0 unchanged", 6'd0);

        // R9: flag stays set during further traffic
        wr("R9 sticky", 6'd8, 32'h0102_0304, '1);
        rd("R9 sticky", 6'd8);
        idle("R9 sticky");

        repeat (3) @(negedge clk);
        total++;
        if (q_due.size() != 0) begin
            bad++;
            $display("FAIL R2 pending results actual=%0d expected=0", q_due.size());
        end
        do_reset();
        rd("R9 cleared by reset", 6'd8);
        repeat (3) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 20000);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule